// File: doc/BRIEF.md
# Interrupt Countdown Timer

This block is a register-programmed timer that requests an interrupt when a count runs out or when a time limit is passed. Software writes through a single-cycle write port. The port gives access to a control word, an initial count, a divider code and a 64-bit deadline. The current count is always visible on an output. There are three modes. In one-shot mode the timer stops at zero. In periodic mode it reloads the initial count each time it expires. In deadline mode it compares a free-running timestamp input against a programmed deadline. Each expiry can produce a one-cycle request pulse, which carries the vector held in the control word.

Writing the initial count starts the count at once. The down-counter then steps once every N clocks, where N comes from the divider code. The control word has no effect on a running count until the count expires. At expiry the block reads the mode and the mask, and from them decides whether to pulse and whether to reload. Moving between one-shot and periodic leaves a running count alone. Moving into or out of deadline mode clears the initial count, the current count and the deadline, so nothing stays armed across that change.

A four-state machine tracks the timer:
- `ST_STOP` means a counting mode with nothing armed.
- `ST_COUNT` means the count is nonzero.
- `ST_DL_IDLE` means deadline mode with a zero deadline.
- `ST_DL_ARMED` means deadline mode with a nonzero deadline.

Transitions:
- **load**: `ST_STOP` to `ST_COUNT` on a nonzero initial-count write.
- **disarm**: `ST_COUNT` to `ST_STOP` on a zero initial-count write.
- **expire-stop**: `ST_COUNT` to `ST_STOP` at a one-shot expiry.
- **expire-reload**: `ST_COUNT` to `ST_COUNT` at a periodic expiry.
- **arm**: `ST_DL_IDLE` to `ST_DL_ARMED` on a nonzero deadline write.
- **fire** or **cancel**: `ST_DL_ARMED` to `ST_DL_IDLE`, either when the deadline is met or on a zero deadline write.
- **enter-deadline**: from `ST_STOP` or `ST_COUNT` to `ST_DL_IDLE`.
- **leave-deadline**: from either deadline state to `ST_STOP`.

Top module: `irq_countdown_timer`

## Requirements
- R1: The write port selects a register with `wr_addr`: 0 is control, 1 is initial count, 2 is divider code, 3 is deadline. Outside deadline mode, an initial-count write of N sets `cur_count` to N after that clock edge. A nonzero N starts the count.
- R2: Divider code c (`wr_data[2:0]`) gives a step period D. D is 1 when c is 7, and 2^(c+1) otherwise. The count drops by one every D clocks, and the first drop comes D edges after the load edge. The initial-count write also restarts the divider.
- R3: Control word fields: vector in bits [7:0], mask in bit 16, mode in bits [18:17]. The modes are 0 one-shot, 1 periodic, 2 deadline. A control write that stays outside deadline mode does not change the running count.
- R4: Expiry happens on the step that takes the count from 1 to 0, which is N·D edges after the load edge. If unmasked, `irq_pulse` goes high for one cycle after that edge, and `irq_vector` carries the vector held at that moment. One-shot mode then leaves the count at 0. Periodic mode reloads N and repeats every N·D edges.
- R5: An initial-count write of zero stops the count at 0. No pulse follows.
- R6: Switching between one-shot and periodic during a count neither restarts nor clears it. The mode in force at expiry decides whether the count reloads.
- R7: A control write that enters or leaves deadline mode clears the initial count, the current count and the deadline to zero. No pulse comes from the count that was cleared.
- R8: Writing a different divider code applies the new period at once, from that edge onward. The current count keeps its value.
- R9: In deadline mode with a nonzero deadline, a single pulse follows the first edge at which `tstamp` is greater than or equal to the deadline. The deadline is then cleared. A zero deadline never fires.
- R10: With the mask bit set at expiry there is no pulse. Periodic reload and deadline clearing still happen.
- R11: In deadline mode, `cur_count` reads 0 and initial-count writes are ignored.
- R12: After reset the block is in one-shot mode, unmasked, with vector 0 and divider code 0 (D=2). The count is 0 and there is no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 control, 1 initial count, 2 divider, 3 deadline) |
| wr_data | input | 64 | Write data |
| tstamp | input | 64 | Timestamp compared against the deadline |
| cur_count | output | 32 | Current down-count value |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector of the latest request |

## Verification
The bench aims at these corner cases:
- **Expiry timing.** The expiry edge must fall exactly at N·D. A divider that is off by one, or that does not restart on load, shows up as a pulse one or more cycles early or late.
- **Control writes during a count.** Control writes mid-count, and one-shot/periodic swaps mid-count, catch a design that restarts or clears on a control write. Such a design would produce a late pulse or none at all.
- **Divider change mid-count.** This catches a design that keeps the old period until the next reload, which would make the pulse late.
- **Deadline mode.** The tests cover deadlines already passed, zero deadlines, masked firing and mode exits. A design that re-fires, keeps a stale deadline after a mode change or after masked expiry, or lets the count run in deadline mode would produce an extra pulse or a nonzero count.

// File: rtl/ictmr_pkg.sv
package ictmr_pkg;

    typedef enum logic [1:0] {
        TM_ONESHOT  = 2'd0,
        TM_PERIODIC = 2'd1,
        TM_DEADLINE = 2'd2,
        TM_RSVD     = 2'd3
    } tmr_mode_e;

    typedef enum logic [1:0] {
        ST_STOP     = 2'd0,
        ST_COUNT    = 2'd1,
        ST_DL_IDLE  = 2'd2,
        ST_DL_ARMED = 2'd3
    } tmr_state_e;

    localparam int ADDR_W   = 2;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_INIT = 2'd1;
    localparam logic [ADDR_W-1:0] A_DIV  = 2'd2;
    localparam logic [ADDR_W-1:0] A_DL   = 2'd3;

    localparam int MASK_BIT = 16;
    localparam int MODE_LSB = 17;

endpackage

// File: rtl/ictmr_prescaler.sv
module ictmr_prescaler #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int PSC_W = (1 << CODE_W) - 1;

    logic [PSC_W-1:0] cnt;
    logic [PSC_W-1:0] lim;

    // all-ones code selects divide by 1, otherwise 2^(code+1)
    always_comb begin
        if (&code) lim = '0;
        else       lim = PSC_W'((32'd1 << (32'(code) + 32'd1)) - 32'd1);
    end

    assign tick = (cnt == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (clear || tick)  cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

    // the divider never runs past its limit (code changes always clear it)
    assert_psc_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= lim);

    // a clear restarts a full period
    assert_psc_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> cnt == '0);

endmodule

// File: rtl/ictmr_deadline_cmp.sv
module ictmr_deadline_cmp #(
    parameter int TS_W = 64
) (
    input  logic            armed,
    input  logic [TS_W-1:0] tstamp,
    input  logic [TS_W-1:0] limit,
    output logic            hit
);
    assign hit = armed && (limit != '0) && (tstamp >= limit);
endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer
    import ictmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int TS_W   = 64,
    parameter int VEC_W  = 8,
    parameter int CODE_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [TS_W-1:0]     wr_data,
    input  logic [TS_W-1:0]     tstamp,
    output logic [CNT_W-1:0]    cur_count,
    output logic                irq_pulse,
    output logic [VEC_W-1:0]    irq_vector
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    tmr_state_e        state, state_nxt;
    tmr_mode_e         ctrl_mode;
    logic              ctrl_mask;
    logic [VEC_W-1:0]  ctrl_vec;
    logic [CODE_W-1:0] div_code;
    logic [CNT_W-1:0]  init_cnt, cur_cnt;
    logic [TS_W-1:0]   dl_val;
    logic              irq_q;
    logic [VEC_W-1:0]  vec_q;

    logic              wr_ctl, wr_init, wr_div, wr_dl;
    logic              in_dl, mode_flip, ld_init, ld_div, psc_clear;
    logic              tick, expire, dl_fire, fire, data_nz;
    tmr_mode_e         new_mode;
    logic [CNT_W-1:0]  data_cnt;

    // ---------------- write decode ----------------
    assign wr_ctl   = wr_en && (wr_addr == A_CTRL);
    assign wr_init  = wr_en && (wr_addr == A_INIT);
    assign wr_div   = wr_en && (wr_addr == A_DIV);
    assign wr_dl    = wr_en && (wr_addr == A_DL);
    assign new_mode = tmr_mode_e'(wr_data[MODE_LSB +: 2]);
    assign data_cnt = wr_data[CNT_W-1:0];
    assign data_nz  = (wr_data != '0);

    assign in_dl     = (ctrl_mode == TM_DEADLINE);
    assign mode_flip = wr_ctl && ((new_mode == TM_DEADLINE) != in_dl);
    assign ld_init   = wr_init && !in_dl;
    assign ld_div    = wr_div && (wr_data[CODE_W-1:0] != div_code);
    assign psc_clear = ld_init || ld_div || mode_flip;

    // ---------------- sub-blocks ----------------
    ictmr_prescaler #(.CODE_W(CODE_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (psc_clear),
        .code  (div_code),
        .tick  (tick)
    );

    ictmr_deadline_cmp #(.TS_W(TS_W)) u_cmp (
        .armed  ((state == ST_DL_ARMED) && !mode_flip),
        .tstamp (tstamp),
        .limit  (dl_val),
        .hit    (dl_fire)
    );

    assign expire = (state == ST_COUNT) && tick && (cur_cnt == CNT_ONE)
                    && !ld_init && !mode_flip;
    assign fire   = expire || dl_fire;

    // ---------------- next state ----------------
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_STOP: begin
                if (mode_flip)                       state_nxt = ST_DL_IDLE;
                else if (ld_init && data_cnt != '0)  state_nxt = ST_COUNT;
            end
            ST_COUNT: begin
                if (mode_flip)      state_nxt = ST_DL_IDLE;
                else if (ld_init)   state_nxt = (data_cnt != '0) ? ST_COUNT : ST_STOP;
                else if (expire)    state_nxt = (ctrl_mode == TM_PERIODIC) ? ST_COUNT : ST_STOP;
            end
            ST_DL_IDLE: begin
                if (mode_flip)               state_nxt = ST_STOP;
                else if (wr_dl && data_nz)   state_nxt = ST_DL_ARMED;
            end
            ST_DL_ARMED: begin
                if (mode_flip)     state_nxt = ST_STOP;
                else if (wr_dl)    state_nxt = data_nz ? ST_DL_ARMED : ST_DL_IDLE;
                else if (dl_fire)  state_nxt = ST_DL_IDLE;
            end
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_STOP;
        else        state <= state_nxt;
    end

    // ---------------- registers and outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_mode <= TM_ONESHOT;
            ctrl_mask <= 1'b0;
            ctrl_vec  <= '0;
            div_code  <= '0;
            init_cnt  <= '0;
            cur_cnt   <= '0;
            dl_val    <= '0;
            irq_q     <= 1'b0;
            vec_q     <= '0;
        end else begin
            irq_q <= 1'b0;
            if (wr_ctl) begin
                ctrl_mode <= new_mode;
                ctrl_mask <= wr_data[MASK_BIT];
                ctrl_vec  <= wr_data[VEC_W-1:0];
            end
            if (wr_div) div_code <= wr_data[CODE_W-1:0];

            if (mode_flip) begin
                init_cnt <= '0;
                cur_cnt  <= '0;
                dl_val   <= '0;
            end else begin
                if (ld_init) begin
                    init_cnt <= data_cnt;
                    cur_cnt  <= data_cnt;
                end else if (expire) begin
                    cur_cnt <= (ctrl_mode == TM_PERIODIC) ? init_cnt : '0;
                end else if ((state == ST_COUNT) && tick) begin
                    cur_cnt <= cur_cnt - CNT_ONE;
                end
                if (wr_dl)        dl_val <= wr_data;
                else if (dl_fire) dl_val <= '0;
            end

            if (fire && !ctrl_mask) begin
                irq_q <= 1'b1;
                vec_q <= ctrl_vec;
            end
        end
    end

    assign cur_count  = cur_cnt;
    assign irq_pulse  = irq_q;
    assign irq_vector = vec_q;

    // ---------------- assertions ----------------
    assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ld_init |=> cur_cnt == $past(data_cnt));

    assert_count_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_dl |-> ((state == ST_COUNT) == (cur_cnt != '0)));

    // without a divider tick and without a load, a control write leaves the count alone
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_COUNT) && !tick && !ld_init && !mode_flip) |=> $stable(cur_cnt));

    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && ctrl_mode == TM_PERIODIC) |=> cur_cnt == $past(init_cnt));

    assert_pulse_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(fire));

    assert_disarm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_init && data_cnt == '0) |=> (cur_cnt == '0 && !irq_pulse));

    assert_flip_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_flip |=> (cur_cnt == '0 && init_cnt == '0 && dl_val == '0 && !irq_pulse));

    assert_mode_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_dl == (state == ST_DL_IDLE || state == ST_DL_ARMED));

    assert_dl_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dl_fire && !wr_dl) |=> dl_val == '0);

    assert_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && ctrl_mask) |=> !irq_pulse);

    assert_dl_count_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_dl |-> cur_cnt == '0);

endmodule

// File: tb/tb_irq_countdown_timer.sv
`timescale 1ns/1ps
module tb_irq_countdown_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [63:0] tstamp = '0;
    logic [31:0] cur_count;
    logic        irq_pulse;
    logic [7:0]  irq_vector;

    localparam logic [1:0] A_CTRL = 2'd0, A_INIT = 2'd1, A_DIV = 2'd2, A_DL = 2'd3;
    localparam int M_ONE = 0, M_PER = 1, M_DL = 2;

    irq_countdown_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tstamp(tstamp), .cur_count(cur_count),
        .irq_pulse(irq_pulse), .irq_vector(irq_vector)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_tests = 0;
    int n_fail  = 0;

    always @(posedge clk) begin
        if (cyc == 180000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic logic [63:0] ctl(int mode, bit mask, int vec);
        return (64'(mode) << 17) | (64'(mask) << 16) | 64'(vec & 8'hff);
    endfunction

    function automatic int div_of(int code);
        return (code == 7) ? 1 : (2 << code);
    endfunction

    task automatic check_eq(input string req, input string what,
                            input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // called at a negedge; the write lands on the next posedge
    task automatic wr(input logic [1:0] a, input logic [63:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_irq(input int limit, output int at);
        at = -1;
        for (int k = 0; k < limit; k++) begin
            if (irq_pulse) begin at = cyc; break; end
            @(negedge clk);
        end
        if (at >= 0) @(negedge clk);
    endtask

    task automatic count_irq(input int n, output int hits);
        hits = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (irq_pulse) hits++;
        end
    endtask

    int t0, at, hits, vec_seen;
    int code, n, per, msk, vec, p;

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        check_eq("R12", "count after reset", cur_count, 0);
        check_eq("R12", "pulse after reset", irq_pulse, 0);
        wr(A_INIT, 64'd3); t0 = cyc;
        check_eq("R1", "count after load", cur_count, 3);
        wait_irq(50, at);
        check_eq("R12", "default divide-by-2 expiry cycle", at, t0 + 3 * div_of(0));
        check_eq("R12", "default vector", irq_vector, 0);
        check_eq("R4", "one-shot count stops at zero", cur_count, 0);

        // R3 control writes during a count
        wr(A_CTRL, ctl(M_ONE, 0, 8'h21));
        wr(A_DIV, 64'd1);
        wr(A_INIT, 64'd40); t0 = cyc;
        repeat (5) @(negedge clk);
        check_eq("R2", "count after 5 cycles at D=4", cur_count, 40 - 5 / 4);
        wr(A_CTRL, ctl(M_ONE, 1, 8'h99));
        wr(A_CTRL, ctl(M_ONE, 0, 8'h5a));
        check_eq("R3", "count unchanged by control writes", cur_count, 40 - 7 / 4);
        wait_irq(300, at);
        check_eq("R3", "expiry cycle after control writes", at, t0 + 40 * div_of(1));
        check_eq("R4", "vector at expiry", irq_vector, 8'h5a);

        // R6 one-shot <-> periodic during a count
        wr(A_DIV, 64'd7);
        wr(A_CTRL, ctl(M_ONE, 0, 8'h30));
        wr(A_INIT, 64'd20); t0 = cyc;
        repeat (5) @(negedge clk);
        wr(A_CTRL, ctl(M_PER, 0, 8'h30));
        check_eq("R6", "count kept on switch to periodic", cur_count, 14);
        wait_irq(40, at);
        check_eq("R6", "first expiry", at, t0 + 20);
        wait_irq(40, at);
        check_eq("R4", "periodic reload interval", at, t0 + 40);
        wr(A_CTRL, ctl(M_ONE, 0, 8'h30));
        wait_irq(40, at);
        check_eq("R6", "expiry after switch back to one-shot", at, t0 + 60);
        count_irq(30, hits);
        check_eq("R6", "one-shot stops after switch", hits, 0);
        check_eq("R6", "count at zero", cur_count, 0);

        // R5 disarm
        wr(A_INIT, 64'd50);
        repeat (3) @(negedge clk);
        wr(A_INIT, 64'd0);
        check_eq("R5", "count after zero write", cur_count, 0);
        count_irq(80, hits);
        check_eq("R5", "no pulse after disarm", hits, 0);

        // R8 divide change mid-count
        wr(A_CTRL, ctl(M_ONE, 0, 8'h44));
        wr(A_DIV, 64'd0);
        wr(A_INIT, 64'd10); t0 = cyc;
        repeat (4) @(negedge clk);
        check_eq("R2", "count after 4 cycles at D=2", cur_count, 8);
        wr(A_DIV, 64'd7);
        check_eq("R8", "count kept on divide change", cur_count, 8);
        wait_irq(40, at);
        check_eq("R8", "new divide applied at once", at, t0 + 13);

        // R10 masked periodic still reloads
        wr(A_CTRL, ctl(M_PER, 1, 8'h11));
        wr(A_INIT, 64'd6); t0 = cyc;
        count_irq(6, hits);
        check_eq("R10", "masked periodic gives no pulse", hits, 0);
        check_eq("R10", "masked periodic reloads", cur_count, 6);
        wr(A_CTRL, ctl(M_PER, 0, 8'h12));
        wait_irq(20, at);
        check_eq("R10", "unmasked pulse after reload", at, t0 + 12);
        check_eq("R4", "vector after unmask", irq_vector, 8'h12);
        wr(A_INIT, 64'd0);
        wr(A_CTRL, ctl(M_ONE, 1, 8'h13));
        wr(A_INIT, 64'd4);
        count_irq(10, hits);
        check_eq("R10", "masked one-shot no pulse", hits, 0);
        check_eq("R10", "masked one-shot stops", cur_count, 0);

        // random counting runs
        for (int it = 0; it < 24; it++) begin
            code = $urandom_range(0, 7);
            n    = $urandom_range(1, 8);
            per  = $urandom_range(0, 1);
            msk  = ($urandom_range(0, 3) == 0) ? 1 : 0;
            vec  = $urandom_range(0, 255);
            p    = n * div_of(code);
            wr(A_CTRL, ctl(per ? M_PER : M_ONE, msk[0], vec));
            wr(A_DIV, 64'(code));
            wr(A_INIT, 64'(n)); t0 = cyc;
            if (msk == 0) begin
                wait_irq(p + 5, at);
                check_eq("R4", "random expiry cycle", at, t0 + p);
                check_eq("R4", "random vector", irq_vector, vec);
                if (per != 0) begin
                    wait_irq(p + 5, at);
                    check_eq("R4", "random periodic second expiry", at, t0 + 2 * p);
                end else begin
                    count_irq(p + 4, hits);
                    check_eq("R4", "random one-shot no repeat", hits, 0);
                    check_eq("R4", "random one-shot count zero", cur_count, 0);
                end
            end else begin
                count_irq(p, hits);
                check_eq("R10", "random masked no pulse", hits, 0);
                check_eq("R10", "random masked count at expiry", cur_count, per ? n : 0);
            end
            wr(A_INIT, 64'd0);
        end

        // R7 enter deadline while counting
        wr(A_DIV, 64'd7);
        wr(A_CTRL, ctl(M_ONE, 0, 8'h70));
        wr(A_INIT, 64'd50);
        repeat (3) @(negedge clk);
        wr(A_CTRL, ctl(M_DL, 0, 8'h77));
        check_eq("R7", "count cleared on entering deadline", cur_count, 0);
        count_irq(60, hits);
        check_eq("R7", "cleared count gives no pulse", hits, 0);

        // R9 / R11 deadline behaviour
        tstamp = 64'd500;
        wr(A_DL, 64'd1000);
        count_irq(5, hits);
        check_eq("R9", "no pulse before deadline", hits, 0);
        wr(A_INIT, 64'd77);
        check_eq("R11", "initial count ignored in deadline mode", cur_count, 0);
        tstamp = 64'd1000;
        @(negedge clk);
        check_eq("R9", "pulse when deadline reached", irq_pulse, 1);
        vec_seen = irq_vector;
        check_eq("R9", "deadline vector", vec_seen, 8'h77);
        count_irq(10, hits);
        check_eq("R9", "single pulse per deadline", hits, 0);
        wr(A_DL, 64'd0);
        tstamp = 64'd5000;
        count_irq(5, hits);
        check_eq("R9", "zero deadline never fires", hits, 0);
        wr(A_DL, 64'd3000); t0 = cyc;
        wait_irq(5, at);
        check_eq("R9", "past deadline fires next edge", at, t0 + 1);

        // R10 masked deadline still clears
        wr(A_CTRL, ctl(M_DL, 1, 8'h78));
        wr(A_DL, 64'd6000);
        tstamp = 64'd7000;
        count_irq(5, hits);
        check_eq("R10", "masked deadline no pulse", hits, 0);
        wr(A_CTRL, ctl(M_DL, 0, 8'h78));
        count_irq(5, hits);
        check_eq("R10", "masked deadline was cleared", hits, 0);

        // R7 leaving deadline clears the deadline
        tstamp = 64'd0;
        wr(A_DL, 64'd100);
        wr(A_CTRL, ctl(M_ONE, 0, 8'h79));
        check_eq("R7", "count zero after leaving deadline", cur_count, 0);
        wr(A_CTRL, ctl(M_DL, 0, 8'h79));
        tstamp = 64'd200;
        count_irq(5, hits);
        check_eq("R7", "deadline cleared by mode round trip", hits, 0);
        wr(A_CTRL, ctl(M_ONE, 0, 8'h7a));
        wr(A_INIT, 64'd5); t0 = cyc;
        wait_irq(20, at);
        check_eq("R7", "counting works after leaving deadline", at, t0 + 5);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule